// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block makes every allocation decision of a virtual-channel router within one clock cycle. Each input port holds several virtual channels (VCs), and each VC may present one flit per cycle together with the output port it is heading for. A VC that already owns an output VC makes an ordinary switch bid. A head flit that still needs an output VC bids for the crossbar in the same cycle as it bids for a VC, assuming that the VC bid will succeed. Both allocations run side by side and are resolved before the clock edge.

Switch allocation has two stages. A first stage picks one VC per input port. A second stage picks one input port per output port. Ordinary bids and speculative bids use separate arbiters. At each output an ordinary bid always masks every speculative one. If a speculative switch win is not matched by a VC win in the same cycle, it is withdrawn and flagged as an abort, and that crossbar slot stays empty. Every arbiter is a matrix arbiter that serves the least recently used requester first. An arbiter updates its order only when its grant is actually consumed.

Flit storage, route computation, credit tracking and the crossbar itself are outside this block. The router supplies the target port of each VC and an idle mask of the downstream VCs, and it uses the grant and abort outputs the same cycle.

Top module: `spec_alloc`

## Requirements
- R1: At most one VC grant is issued per output port per cycle, and only to a valid VC with `req_has_ovc` low. The granted VC number is the lowest-numbered idle downstream VC of that output port. Downstream VC w of output port o is bit o*NVC+w of `ovc_free`. Input VC v of input port p is bit index k = p*NVC+v.
- R2: A head VC whose target output has no idle downstream VC receives no VC grant.
- R3: At most one VC of any input port receives a switch grant per cycle.
- R4: At most one input VC targeting any given output port receives a switch grant per cycle.
- R5: A VC with `req_has_ovc` high (non-speculative) is never blocked by a speculative bid. At an output, any non-speculative bid excludes all speculative ones. An input port with any non-speculative bid sends no speculative bid that cycle.
- R6: A speculative VC that wins switch arbitration gets `sw_gnt` only if it also receives `vc_gnt` that cycle. Otherwise `spec_abort` is raised for it and `sw_gnt` stays low. A VC that loses switch arbitration never sees an abort.
- R7: Every arbiter serves least recently served first. After reset, the lower index has priority. A requester whose grant was used drops to the lowest priority.
- R8: An aborted speculative grant leaves the priority order of the switch arbiters unchanged.
- R9: With no valid requests, all grant and abort outputs are zero, including right after reset.
- R10: All grants and aborts depend combinationally on the current-cycle inputs and appear in the same cycle as the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT*NVC | Per input VC: a flit is bidding this cycle |
| req_has_ovc | input | NPORT*NVC | Per input VC: output VC already held (non-speculative bid) |
| req_port | input | NPORT*NVC*PW | Per input VC: target output port, PW bits each |
| ovc_free | input | NPORT*NVC | Per downstream VC: idle and allocatable |
| vc_gnt | output | NPORT*NVC | Per input VC: output VC allocated this cycle |
| vc_gnt_id | output | NPORT*NVC*VW | Per input VC: number of the allocated output VC |
| sw_gnt | output | NPORT*NVC | Per input VC: crossbar traversal granted |
| spec_abort | output | NPORT*NVC | Per input VC: speculative switch win cancelled |

## Verification
The bench uses the defaults NPORT=5 and NVC=4: a five-port router with four VCs per input, 20 input VCs and 3-bit port fields. This makes contention reachable at all three levels. Two VCs of one input port meet in the first-stage arbiter. Two input ports meet at one output in the second stage. Two head flits compete for a partly idle set of downstream VCs. With four downstream VCs per port, the bench can place idle masks whose lowest set bit is at index 0, 1, 2 or 3. Back-to-back cycles with the same bids then show how the priority order moves after a used grant and stays put after an aborted one.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;
  // index of the lowest set bit, 0 when none
  function automatic int unsigned low_idx(input logic [31:0] m, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/sa_mtx_arb.sv
module sa_mtx_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] gnt
);
  // pri_q[i][j] = 1 : requester i is ahead of requester j
  logic [N-1:0][N-1:0] pri_q, pri_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && pri_q[j][i]) blk = 1'b1;
      end
      gnt[i] = req[i] & ~blk;
    end
  end

  always_comb begin
    pri_d = pri_q;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) begin
        for (int j = 0; j < N; j++) begin
          if (j != k) begin
            pri_d[k][j] = 1'b0;
            pri_d[j][k] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          pri_q[i][j] <= (i < j);
    end else if (upd) begin
      pri_q <= pri_d;
    end
  end
endmodule

// File: rtl/spec_alloc.sv
module spec_alloc
  import spec_alloc_pkg::*;
#(
  parameter  int NPORT = 5,
  parameter  int NVC   = 4,
  localparam int NI    = NPORT * NVC,
  localparam int PW    = $clog2(NPORT),
  localparam int VW    = $clog2(NVC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    req_valid,
  input  logic [NI-1:0]    req_has_ovc,
  input  logic [NI*PW-1:0] req_port,
  input  logic [NI-1:0]    ovc_free,
  output logic [NI-1:0]    vc_gnt,
  output logic [NI*VW-1:0] vc_gnt_id,
  output logic [NI-1:0]    sw_gnt,
  output logic [NI-1:0]    spec_abort
);
  logic [NI-1:0]          head, nsr;
  logic [NI-1:0][PW-1:0]  dst;

  always_comb begin
    for (int k = 0; k < NI; k++) begin
      dst[k]  = req_port[k*PW +: PW];
      head[k] = req_valid[k] & ~req_has_ovc[k];
      nsr[k]  = req_valid[k] & req_has_ovc[k];
    end
  end

  // ---------------- VC allocation, one arbiter per output port
  logic [NPORT-1:0][NI-1:0] va_req, va_gnt;
  logic [NPORT-1:0]         va_any;
  logic [NPORT-1:0][VW-1:0] va_id;

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      va_any[o] = |ovc_free[o*NVC +: NVC];
      va_id[o]  = VW'(low_idx(32'(ovc_free[o*NVC +: NVC]), NVC));
      for (int k = 0; k < NI; k++)
        va_req[o][k] = head[k] && (dst[k] == PW'(o)) && va_any[o];
    end
  end

  // ---------------- switch allocation stage arrays
  logic [NPORT-1:0][NVC-1:0] s1n_req, s1s_req, s1n_gnt, s1s_gnt;
  logic [NPORT-1:0]          s1n_upd, s1s_upd;
  logic [NPORT-1:0]          has_ns, has_sp;
  logic [NPORT-1:0][PW-1:0]  n_dst, s_dst;
  logic [NPORT-1:0][NPORT-1:0] s2n_req, s2s_req, s2n_gnt, s2s_gnt;
  logic [NPORT-1:0]          nsa, s2s_upd;
  logic [NPORT-1:0]          in_n, in_s, sp_ok;

  generate
    for (genvar o = 0; o < NPORT; o++) begin : g_out
      sa_mtx_arb #(.N(NI)) u_va (
        .clk(clk), .rst_n(rst_n), .req(va_req[o]), .upd(va_any[o]), .gnt(va_gnt[o]));
      sa_mtx_arb #(.N(NPORT)) u_s2n (
        .clk(clk), .rst_n(rst_n), .req(s2n_req[o]), .upd(nsa[o]), .gnt(s2n_gnt[o]));
      sa_mtx_arb #(.N(NPORT)) u_s2s (
        .clk(clk), .rst_n(rst_n), .req(s2s_req[o]), .upd(s2s_upd[o]), .gnt(s2s_gnt[o]));
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_in
      sa_mtx_arb #(.N(NVC)) u_s1n (
        .clk(clk), .rst_n(rst_n), .req(s1n_req[p]), .upd(s1n_upd[p]), .gnt(s1n_gnt[p]));
      sa_mtx_arb #(.N(NVC)) u_s1s (
        .clk(clk), .rst_n(rst_n), .req(s1s_req[p]), .upd(s1s_upd[p]), .gnt(s1s_gnt[p]));
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NI; k++) begin
      vc_gnt[k] = 1'b0;
      vc_gnt_id[k*VW +: VW] = '0;
      for (int o = 0; o < NPORT; o++) begin
        if (va_gnt[o][k]) begin
          vc_gnt[k] = 1'b1;
          vc_gnt_id[k*VW +: VW] = va_id[o];
        end
      end
    end
  end

  // ---------------- stage 1: one VC per input, split by bid class
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      s1n_req[p] = nsr[p*NVC +: NVC];
      s1s_req[p] = head[p*NVC +: NVC];
      has_ns[p]  = |s1n_req[p];
      has_sp[p]  = |s1s_req[p];
      n_dst[p]   = '0;
      s_dst[p]   = '0;
      for (int v = 0; v < NVC; v++) begin
        if (s1n_gnt[p][v]) n_dst[p] = dst[p*NVC + v];
        if (s1s_gnt[p][v]) s_dst[p] = dst[p*NVC + v];
      end
    end
  end

  // ---------------- stage 2: one input per output, speculative masked
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int p = 0; p < NPORT; p++) begin
        s2n_req[o][p] = has_ns[p] && (n_dst[p] == PW'(o));
        s2s_req[o][p] = !has_ns[p] && has_sp[p] && (s_dst[p] == PW'(o));
      end
      nsa[o] = |s2n_req[o];
    end
  end

  // ---------------- merge, abort and priority-update enables
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      in_n[p] = 1'b0;
      in_s[p] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        in_n[p] = in_n[p] | s2n_gnt[o][p];
        in_s[p] = in_s[p] | (s2s_gnt[o][p] & ~nsa[o]);
      end
      sp_ok[p]   = in_s[p] & |(s1s_gnt[p] & vc_gnt[p*NVC +: NVC]);
      s1n_upd[p] = in_n[p];
      s1s_upd[p] = sp_ok[p];
      for (int v = 0; v < NVC; v++) begin
        sw_gnt[p*NVC + v]     = (s1n_gnt[p][v] & in_n[p]) |
                                (s1s_gnt[p][v] & in_s[p] & vc_gnt[p*NVC + v]);
        spec_abort[p*NVC + v] = s1s_gnt[p][v] & in_s[p] & ~vc_gnt[p*NVC + v];
      end
    end
    for (int o = 0; o < NPORT; o++)
      s2s_upd[o] = ~nsa[o] & |(s2s_gnt[o] & sp_ok);
  end
endmodule

// File: rtl/spec_alloc_chk.sv
module spec_alloc_chk #(
  parameter  int NPORT = 5,
  parameter  int NVC   = 4,
  localparam int NI    = NPORT * NVC,
  localparam int PW    = $clog2(NPORT),
  localparam int VW    = $clog2(NVC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NI-1:0]    req_valid,
  input logic [NI-1:0]    req_has_ovc,
  input logic [NI*PW-1:0] req_port,
  input logic [NI-1:0]    ovc_free,
  input logic [NI-1:0]    vc_gnt,
  input logic [NI*VW-1:0] vc_gnt_id,
  input logic [NI-1:0]    sw_gnt,
  input logic [NI-1:0]    spec_abort
);
  int unsigned sw_cnt [NPORT];
  int unsigned vc_cnt [NPORT];
  logic        bad_free;

  always_comb begin
    bad_free = 1'b0;
    for (int o = 0; o < NPORT; o++) begin
      sw_cnt[o] = 0;
      vc_cnt[o] = 0;
    end
    for (int k = 0; k < NI; k++) begin
      int unsigned pt, ix;
      pt = int'(req_port[k*PW +: PW]);
      ix = pt * NVC + int'(vc_gnt_id[k*VW +: VW]);
      for (int o = 0; o < NPORT; o++) begin
        if (pt == o && sw_gnt[k]) sw_cnt[o]++;
        if (pt == o && vc_gnt[k]) vc_cnt[o]++;
      end
      if (vc_gnt[k]) begin
        if (pt >= NPORT || ix >= NI) bad_free = 1'b1;
        else if (!ovc_free[ix]) bad_free = 1'b1;
      end
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_p
      // R3
      in_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_gnt[p*NVC +: NVC]) <= 1);
      // R4
      out_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cnt[p] <= 1);
      // R1
      vc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_cnt[p] <= 1);
    end
  endgenerate

  // R1
  vc_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_gnt & ~(req_valid & ~req_has_ovc)) == '0);
  // R2
  vc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_free);
  // R6
  spec_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_gnt & ~req_has_ovc & ~vc_gnt) == '0);
  // R6
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_abort & (sw_gnt | vc_gnt | ~req_valid | req_has_ovc)) == '0);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> ((sw_gnt | vc_gnt | spec_abort) == '0));
endmodule

bind spec_alloc spec_alloc_chk #(.NPORT(NPORT), .NVC(NVC)) u_chk (.*);

// File: tb/spec_alloc_tb.sv
module spec_alloc_tb;
  localparam int NPORT = 5;
  localparam int NVC   = 4;
  localparam int NI    = NPORT * NVC;
  localparam int PW    = 3;
  localparam int VW    = 2;

  logic             clk;
  logic             rst_n;
  logic [NI-1:0]    req_valid, req_has_ovc, ovc_free;
  logic [NI*PW-1:0] req_port;
  logic [NI-1:0]    vc_gnt, sw_gnt, spec_abort;
  logic [NI*VW-1:0] vc_gnt_id;

  int errs = 0;
  int nchk = 0;
  bit done = 0;

  spec_alloc #(.NPORT(NPORT), .NVC(NVC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_has_ovc(req_has_ovc),
    .req_port(req_port), .ovc_free(ovc_free), .vc_gnt(vc_gnt),
    .vc_gnt_id(vc_gnt_id), .sw_gnt(sw_gnt), .spec_abort(spec_abort));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [4:0] idx;
    logic       ns;
    logic [2:0] port;
    logic [3:0] free;
    logic       vcg;
    logic [1:0] id;
    logic       sw;
    logic       ab;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{5'd0,  1'b1, 3'd1, 4'h0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{5'd5,  1'b0, 3'd2, 4'h6, 1'b1, 2'd1, 1'b1, 1'b0},
    '{5'd7,  1'b0, 3'd0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b1},
    '{5'd19, 1'b0, 3'd4, 4'h8, 1'b1, 2'd3, 1'b1, 1'b0},
    '{5'd12, 1'b1, 3'd3, 4'h0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{5'd3,  1'b0, 3'd4, 4'hF, 1'b1, 2'd0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_valid   = '0;
    req_has_ovc = '0;
    req_port    = '0;
    ovc_free    = '0;
  endtask

  task automatic bid(input int k, input logic ns, input int pt);
    req_valid[k]         = 1'b1;
    req_has_ovc[k]       = ns;
    req_port[k*PW +: PW] = PW'(pt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset sw_gnt", 32'(sw_gnt), 0);
    check("R9 reset vc_gnt", 32'(vc_gnt), 0);
    check("R9 reset abort", 32'(spec_abort), 0);

    // table: one bidder each, same-cycle response (R10, R1, R2, R6)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      clr();
      bid(int'(TBL[i].idx), TBL[i].ns, int'(TBL[i].port));
      ovc_free[int'(TBL[i].port)*NVC +: NVC] = TBL[i].free;
      #1;
      check("R10 sw_gnt", 32'(sw_gnt), 32'(TBL[i].sw) << TBL[i].idx);
      check("R1 vc_gnt", 32'(vc_gnt), 32'(TBL[i].vcg) << TBL[i].idx);
      if (TBL[i].vcg)
        check("R1 vc_gnt_id", 32'(vc_gnt_id[int'(TBL[i].idx)*VW +: VW]), 32'(TBL[i].id));
      check("R6 abort", 32'(spec_abort), 32'(TBL[i].ab) << TBL[i].idx);
    end

    // R5: non-speculative bid masks speculative bid at the same output
    do_reset();
    bid(0, 1'b1, 2); bid(4, 1'b0, 2); ovc_free[8 +: 4] = 4'hF;
    #1;
    check("R5 ns wins output", 32'(sw_gnt), 32'h1);
    check("R5 spec still gets vc", 32'(vc_gnt), 32'h10);
    check("R6 loser no abort", 32'(spec_abort), 0);

    // R5: input with a non-speculative bid sends no speculative one
    @(negedge clk);
    clr();
    bid(0, 1'b1, 1); bid(1, 1'b0, 3); ovc_free[12 +: 4] = 4'hF;
    #1;
    check("R5 input mask sw", 32'(sw_gnt), 32'h1);
    check("R5 input mask vc", 32'(vc_gnt), 32'h2);
    check("R3 input mask abort", 32'(spec_abort), 0);

    // R7: output contention rotates
    do_reset();
    bid(0, 1'b1, 2); bid(4, 1'b1, 2);
    #1; check("R7 out rr 0", 32'(sw_gnt), 32'h1);
    @(negedge clk); #1; check("R7 out rr 1", 32'(sw_gnt), 32'h10);
    @(negedge clk); #1; check("R7 out rr 2", 32'(sw_gnt), 32'h1);

    // R7: first-stage VC contention rotates
    do_reset();
    bid(0, 1'b1, 1); bid(1, 1'b1, 3);
    #1; check("R7 vc rr 0", 32'(sw_gnt), 32'h1);
    @(negedge clk); #1; check("R7 vc rr 1", 32'(sw_gnt), 32'h2);

    // R8: aborted speculative grant keeps the order
    do_reset();
    bid(0, 1'b0, 2); bid(4, 1'b0, 2);
    #1;
    check("R6 abort no idle vc", 32'(spec_abort), 32'h1);
    check("R6 abort no sw", 32'(sw_gnt), 0);
    @(negedge clk);
    ovc_free[8 +: 4] = 4'h1;
    #1;
    check("R8 order kept sw", 32'(sw_gnt), 32'h1);
    check("R8 order kept vc", 32'(vc_gnt), 32'h1);
    check("R8 no abort", 32'(spec_abort), 0);

    // R1/R7: two heads, partly idle VCs, rotation of both allocators
    do_reset();
    bid(0, 1'b0, 3); bid(4, 1'b0, 3); ovc_free[12 +: 4] = 4'hC;
    #1;
    check("R1 one vc gnt", 32'(vc_gnt), 32'h1);
    check("R1 lowest idle id", 32'(vc_gnt_id[0 +: VW]), 2);
    check("R4 spec sw", 32'(sw_gnt), 32'h1);
    check("R6 loser quiet", 32'(spec_abort), 0);
    @(negedge clk); #1;
    check("R7 vc alloc rotates", 32'(vc_gnt), 32'h10);
    check("R1 id after rotate", 32'(vc_gnt_id[4*VW +: VW]), 2);
    check("R7 spec sw rotates", 32'(sw_gnt), 32'h10);

    @(negedge clk);
    clr();
    #1;
    check("R9 idle outputs", 32'(sw_gnt | vc_gnt | spec_abort), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errs++;
      nchk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule